// File: doc/BRIEF.md
# I2C Master Start Condition Generator

This block produces the opening Start condition of an I2C master transfer. Software sets the start bit in a 5-bit command register; if both bus lines are seen high, the block times one baud period, pulls SDA low while SCL stays released, times a second baud period, and then clears the start bit and raises its interrupt flag. SDA is left held low for the phases that follow.

Each period is timed by a reloadable down-counter. The counter is loaded from a 7-bit reload value and steps once per clock, so one period lasts reload + 1 clocks. Both lines are open-drain: an output enable of 1 pulls the line low, and 0 lets it float high. The line inputs pass through a two-flop synchronizer before the control logic reads them.

While the sequence runs, the block watches for a bus collision and aborts if one occurs. A write to the transmit buffer during the sequence raises a write-collision flag, and new commands are locked out until the sequence ends.

Top module: `i2c_start_gen`

## Requirements
- R1: A control write with command bit 0 set, made while idle and with both synchronized lines high, makes busy_o high from the next edge and loads the baud counter with reload_i.
- R2: With reload value N, sda_oe_o rises N+1 clocks after the accepting edge (edge e0+N+1), start_seen_o is set at the same edge, and scl_oe_o stays 0 throughout.
- R3: N+1 clocks after SDA goes low (edge e0+2N+2), command bit 0 clears, irq_o sets and busy_o falls, while sda_oe_o stays 1.
- R4: A start request made while either synchronized line is low sets bcol_o, leaves command bit 0 clear and busy_o low, and does not drive SDA.
- R5: If either synchronized line is low during the first period, the block aborts: bcol_o sets, busy_o falls, command bit 0 clears, SDA stays released and start_seen_o stays 0.
- R6: A transmit-buffer write while busy_o is high sets wcol_o and leaves buf_o unchanged; a write while idle loads buf_o on the next edge.
- R7: Control writes while busy_o is high are ignored: all five command bits keep their value.
- R8: wcol_o, bcol_o and irq_o are sticky. A flag write clears each flag whose bit in flag_wdata_i is 0 (bit 0 wcol, bit 1 bcol, bit 2 irq) and leaves those written 1; a set in the same cycle wins.
- R9: A control write while idle with bit 0 clear stores all five bits and releases the SDA hold.
- R10: After reset all outputs are 0, the command and buffer are cleared and the synchronizers read both lines as high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reload_i | input | RELOAD_W | Baud reload value; one period is reload_i+1 clocks |
| ctrl_wr_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 5 | Command bits; bit 0 requests a Start |
| cmd_o | output | 5 | Current command register |
| flag_wr_i | input | 1 | Flag write strobe |
| flag_wdata_i | input | 3 | Write 0 to a bit to clear that flag (0 wcol, 1 bcol, 2 irq) |
| buf_wr_i | input | 1 | Transmit buffer write strobe |
| buf_wdata_i | input | DATA_W | Transmit buffer write data |
| buf_o | output | DATA_W | Transmit buffer contents |
| sda_i | input | 1 | SDA line level |
| scl_i | input | 1 | SCL line level |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| busy_o | output | 1 | Start sequence in progress |
| start_seen_o | output | 1 | Start condition produced |
| irq_o | output | 1 | Sticky completion interrupt flag |
| bcol_o | output | 1 | Sticky bus-collision flag |
| wcol_o | output | 1 | Sticky write-collision flag |

## Verification
The bench measures, for reload values of 0, the maximum and a random set in between, the exact number of clocks until SDA falls and until the start bit clears. An off-by-one counter or a skipped reload would move either edge by a cycle. It pulls SCL low partway through the first period, and it requests a Start with the lines already low. A design that checked the lines only at the end of the period, or not at all, would still drive SDA and set start_seen_o. Writes to the buffer and to the control register during a sequence show whether a design lets the data through or queues a command, and partial flag writes show whether clearing touches only the bits written as 0.

// File: rtl/i2c_start_pkg.sv
package i2c_start_pkg;
  localparam int CMD_W    = 5;
  localparam int FLAG_N   = 3;
  localparam int FLG_WCOL = 0;
  localparam int FLG_BCOL = 1;
  localparam int FLG_IRQ  = 2;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_WAIT_HI = 2'd1,
    ST_HOLD_LO = 2'd2
  } start_st_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_line
    logic [STAGES-1:0] sh_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= '1;
      else         sh_q <= {sh_q[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = sh_q[STAGES-1];
  end
endmodule

// File: rtl/i2c_baud_cnt.sv
module i2c_baud_cnt #(
  parameter int W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         run_i,
  input  logic [W-1:0] reload_i,
  output logic         expire_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (load_i)                 cnt_q <= reload_i;
    else if (run_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expire_o = run_i && (cnt_q == '0);

  assert_reload_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(reload_i)));

  assert_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/i2c_start_fsm.sv
module i2c_start_fsm
  import i2c_start_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_wr_i,
  input  logic [CMD_W-1:0] ctrl_wdata_i,
  input  logic             flag_wr_i,
  input  logic [FLAG_N-1:0] flag_wdata_i,
  input  logic             buf_wr_i,
  input  logic             sda_s_i,
  input  logic             scl_s_i,
  input  logic             expire_i,
  output logic             load_o,
  output logic             run_o,
  output logic             buf_accept_o,
  output logic             busy_o,
  output logic             sda_oe_o,
  output logic             start_seen_o,
  output logic [CMD_W-1:0] cmd_o,
  output logic [FLAG_N-1:0] flags_o
);
  start_st_e          st_q;
  logic [CMD_W-1:0]   cmd_q;
  logic               sda_hold_q;
  logic               seen_q;
  logic [FLAG_N-1:0]  flag_q;
  logic [FLAG_N-1:0]  flag_set;
  logic               lines_hi;
  logic               req;

  assign lines_hi = sda_s_i && scl_s_i;
  assign req      = ctrl_wr_i && ctrl_wdata_i[0] && (st_q == ST_IDLE);
  assign run_o    = (st_q != ST_IDLE);
  assign busy_o   = run_o;

  always_comb begin
    load_o = (req && lines_hi) ||
             ((st_q == ST_WAIT_HI) && lines_hi && expire_i);
    flag_set           = '0;
    flag_set[FLG_WCOL] = buf_wr_i && busy_o;
    flag_set[FLG_BCOL] = (req && !lines_hi) || ((st_q == ST_WAIT_HI) && !lines_hi);
    flag_set[FLG_IRQ]  = (st_q == ST_HOLD_LO) && expire_i;
  end

  assign buf_accept_o = buf_wr_i && !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      cmd_q      <= '0;
      sda_hold_q <= 1'b0;
      seen_q     <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (ctrl_wr_i) begin
            cmd_q <= ctrl_wdata_i;
            if (ctrl_wdata_i[0]) begin
              seen_q <= 1'b0;
              if (lines_hi) st_q     <= ST_WAIT_HI;
              else          cmd_q[0] <= 1'b0;
            end else begin
              sda_hold_q <= 1'b0;
            end
          end
        end
        ST_WAIT_HI: begin
          if (!lines_hi) begin
            st_q     <= ST_IDLE;
            cmd_q[0] <= 1'b0;
          end else if (expire_i) begin
            st_q       <= ST_HOLD_LO;
            sda_hold_q <= 1'b1;
            seen_q     <= 1'b1;
          end
        end
        ST_HOLD_LO: begin
          if (expire_i) begin
            st_q     <= ST_IDLE;
            cmd_q[0] <= 1'b0;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  for (genvar f = 0; f < FLAG_N; f++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            flag_q[f] <= 1'b0;
      else if (flag_set[f])                   flag_q[f] <= 1'b1;
      else if (flag_wr_i && !flag_wdata_i[f]) flag_q[f] <= 1'b0;
    end
  end

  assign sda_oe_o     = sda_hold_q;
  assign start_seen_o = seen_q;
  assign cmd_o        = cmd_q;
  assign flags_o      = flag_q;

  assert_sda_after_high_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> $past(sda_s_i && scl_s_i));

  assert_done_holds_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q[FLG_IRQ]) |-> (sda_oe_o && !busy_o && !cmd_q[0]));

  assert_abort_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q[FLG_BCOL]) |-> (!busy_o && !cmd_q[0]));

  assert_cmd_locked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (cmd_q[CMD_W-1:1] == $past(cmd_q[CMD_W-1:1])));
endmodule

// File: rtl/i2c_tx_buf.sv
module i2c_tx_buf #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         accept_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       q_o <= '0;
    else if (accept_i) q_o <= data_i;
  end
endmodule

// File: rtl/i2c_start_gen.sv
module i2c_start_gen
  import i2c_start_pkg::*;
#(
  parameter int RELOAD_W    = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [RELOAD_W-1:0] reload_i,
  input  logic                ctrl_wr_i,
  input  logic [CMD_W-1:0]    ctrl_wdata_i,
  output logic [CMD_W-1:0]    cmd_o,
  input  logic                flag_wr_i,
  input  logic [FLAG_N-1:0]   flag_wdata_i,
  input  logic                buf_wr_i,
  input  logic [DATA_W-1:0]   buf_wdata_i,
  output logic [DATA_W-1:0]   buf_o,
  input  logic                sda_i,
  input  logic                scl_i,
  output logic                sda_oe_o,
  output logic                scl_oe_o,
  output logic                busy_o,
  output logic                start_seen_o,
  output logic                irq_o,
  output logic                bcol_o,
  output logic                wcol_o
);
  localparam int LINES = 2;

  logic [LINES-1:0]  line_s;
  logic              load, run, expire, buf_accept;
  logic [FLAG_N-1:0] flags;

  i2c_line_sync #(.W(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   (line_s)
  );

  i2c_baud_cnt #(.W(RELOAD_W)) u_baud (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .run_i   (run),
    .reload_i(reload_i),
    .expire_o(expire)
  );

  i2c_start_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctrl_wr_i   (ctrl_wr_i),
    .ctrl_wdata_i(ctrl_wdata_i),
    .flag_wr_i   (flag_wr_i),
    .flag_wdata_i(flag_wdata_i),
    .buf_wr_i    (buf_wr_i),
    .sda_s_i     (line_s[0]),
    .scl_s_i     (line_s[1]),
    .expire_i    (expire),
    .load_o      (load),
    .run_o       (run),
    .buf_accept_o(buf_accept),
    .busy_o      (busy_o),
    .sda_oe_o    (sda_oe_o),
    .start_seen_o(start_seen_o),
    .cmd_o       (cmd_o),
    .flags_o     (flags)
  );

  i2c_tx_buf #(.W(DATA_W)) u_buf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .accept_i(buf_accept),
    .data_i  (buf_wdata_i),
    .q_o     (buf_o)
  );

  assign scl_oe_o = 1'b0;  // SCL stays released for the whole Start
  assign irq_o    = flags[FLG_IRQ];
  assign bcol_o   = flags[FLG_BCOL];
  assign wcol_o   = flags[FLG_WCOL];

  assert_buf_frozen_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (buf_wr_i && busy_o) |=> ($stable(buf_o) && wcol_o));

  assert_scl_free_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !scl_oe_o);
endmodule

// File: tb/tb_i2c_start_gen.sv
module tb_i2c_start_gen;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [6:0] reload_i = '0;
  logic       ctrl_wr_i = 1'b0;
  logic [4:0] ctrl_wdata_i = '0;
  logic [4:0] cmd_o;
  logic       flag_wr_i = 1'b0;
  logic [2:0] flag_wdata_i = '0;
  logic       buf_wr_i = 1'b0;
  logic [7:0] buf_wdata_i = '0;
  logic [7:0] buf_o;
  logic       sda_oe_o, scl_oe_o, busy_o, start_seen_o, irq_o, bcol_o, wcol_o;
  logic       tb_sda_pull = 1'b0, tb_scl_pull = 1'b0;
  logic       sda_i, scl_i;
  int         checks = 0, errors = 0;

  assign sda_i = ~(sda_oe_o | tb_sda_pull);
  assign scl_i = ~(scl_oe_o | tb_scl_pull);

  always #2.5 clk_i = ~clk_i;

  i2c_start_gen dut (.*);

  function automatic int exp_low_at(int n);  return n + 2;     endfunction
  function automatic int exp_done_at(int n); return 2 * n + 3; endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      ctrl_wr_i = 1'b0; buf_wr_i = 1'b0; flag_wr_i = 1'b0;
    end
  endtask

  task automatic clear_and_release();
    @(negedge clk_i);
    flag_wr_i = 1'b1; flag_wdata_i = 3'b000;
    ctrl_wr_i = 1'b1; ctrl_wdata_i = 5'b00000;
    idle_cycles(4);
    chk(!sda_oe_o && !irq_o && !bcol_o && !wcol_o, "R9 release/clear", {sda_oe_o, irq_o, bcol_o, wcol_o}, 0);
  endtask

  task automatic run_start(input int n, input bit hit_buf, input bit hit_ctrl);
    int t_low, t_done;
    logic [7:0] old_buf;
    reload_i = 7'(n);
    @(negedge clk_i);
    ctrl_wr_i = 1'b1; ctrl_wdata_i = 5'b00001;
    old_buf = buf_o;
    t_low = 0; t_done = 0;
    for (int k = 1; k <= 2 * n + 10; k++) begin
      @(negedge clk_i);
      ctrl_wr_i = 1'b0; buf_wr_i = 1'b0; flag_wr_i = 1'b0;
      if (sda_oe_o && t_low == 0) t_low = k;
      if (!cmd_o[0] && t_done == 0) t_done = k;
      if (scl_oe_o) chk(1'b0, "R2 scl released", 1, 0);
      if (k == 1) begin
        chk(busy_o, "R1 busy after request", busy_o, 1);
        if (hit_buf) begin buf_wr_i = 1'b1; buf_wdata_i = ~old_buf; end
        if (hit_ctrl) begin ctrl_wr_i = 1'b1; ctrl_wdata_i = 5'b11110; end
      end
      if (k == 2) begin
        if (hit_buf) begin
          chk(buf_o == old_buf, "R6 buffer unchanged", buf_o, old_buf);
          chk(wcol_o, "R6 wcol set", wcol_o, 1);
        end
        if (hit_ctrl) chk(cmd_o == 5'b00001, "R7 command locked", cmd_o, 1);
      end
    end
    chk(t_low == exp_low_at(n), "R2 sda low timing", t_low, exp_low_at(n));
    chk(t_done == exp_done_at(n), "R3 done timing", t_done, exp_done_at(n));
    chk(irq_o && start_seen_o && sda_oe_o && !busy_o, "R3 end state",
        {irq_o, start_seen_o, sda_oe_o, busy_o}, 4'b1110);
    clear_and_release();
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk_i);
      cyc++;
      if (cyc > 150000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd20240517));
    #12 rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!sda_oe_o && !scl_oe_o && !busy_o && !start_seen_o && !irq_o && !bcol_o && !wcol_o
        && cmd_o == 0 && buf_o == 0, "R10 reset state", {busy_o, cmd_o, buf_o}, 0);

    // R6: idle write loads the buffer
    buf_wr_i = 1'b1; buf_wdata_i = 8'hA5;
    idle_cycles(1);
    chk(buf_o == 8'hA5 && !wcol_o, "R6 idle buffer write", buf_o, 8'hA5);

    // R9: idle control write stores all bits, no start
    ctrl_wr_i = 1'b1; ctrl_wdata_i = 5'b10110;
    idle_cycles(1);
    chk(cmd_o == 5'b10110 && !busy_o, "R9 stored command", cmd_o, 5'b10110);

    run_start(0, 1'b1, 1'b1);
    run_start(127, 1'b0, 1'b1);
    for (int it = 0; it < 8; it++)
      run_start(int'($urandom_range(1, 20)), 1'($urandom), 1'($urandom));

    // R5: SCL pulled low during first period
    reload_i = 7'd10;
    @(negedge clk_i);
    ctrl_wr_i = 1'b1; ctrl_wdata_i = 5'b00001;
    idle_cycles(2);
    tb_scl_pull = 1'b1;
    idle_cycles(20);
    chk(bcol_o && !busy_o && !sda_oe_o && !start_seen_o && !cmd_o[0], "R5 abort on scl low",
        {bcol_o, busy_o, sda_oe_o, start_seen_o}, 4'b1000);
    tb_scl_pull = 1'b0;

    // R8: partial clear leaves other flags
    buf_wr_i = 1'b0;
    @(negedge clk_i);
    flag_wr_i = 1'b1; flag_wdata_i = 3'b111;
    idle_cycles(1);
    chk(bcol_o, "R8 write 1 keeps bcol", bcol_o, 1);
    flag_wr_i = 1'b1; flag_wdata_i = 3'b101;
    idle_cycles(1);
    chk(!bcol_o, "R8 write 0 clears bcol", bcol_o, 0);
    idle_cycles(3);

    // R4: request with both lines low
    tb_sda_pull = 1'b1; tb_scl_pull = 1'b1;
    idle_cycles(4);
    ctrl_wr_i = 1'b1; ctrl_wdata_i = 5'b00001;
    idle_cycles(1);
    chk(bcol_o && !busy_o && !cmd_o[0] && !sda_oe_o, "R4 request with lines low",
        {bcol_o, busy_o, cmd_o[0], sda_oe_o}, 4'b1000);
    idle_cycles(3);
    chk(!busy_o, "R4 stays idle", busy_o, 0);
    tb_sda_pull = 1'b0;
    idle_cycles(4);

    // R4: only SCL low
    @(negedge clk_i);
    flag_wr_i = 1'b1; flag_wdata_i = 3'b000;
    idle_cycles(1);
    ctrl_wr_i = 1'b1; ctrl_wdata_i = 5'b00001;
    idle_cycles(1);
    chk(bcol_o && !busy_o, "R4 request with scl low", {bcol_o, busy_o}, 2'b10);
    tb_scl_pull = 1'b0;
    idle_cycles(4);
    clear_and_release();

    // R1: normal start after collisions still works
    run_start(5, 1'b1, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule